// File: doc/BRIEF.md
# Sequential Field Memory with Staged Burst Writes

This block is a serial-access byte store with an independent write side and read side sharing one word array. Neither side takes an address. Each side keeps its own pointer, which steps by one on every active cycle, wraps to zero at the array depth and returns to zero only when that side's pointer-reset input is seen. Both sides run on one clock. A per-side strobe stands in for the serial shift clock, so a side does nothing on a cycle where its strobe is low.

Incoming bytes are not written to the array one at a time. They collect in a staging register as wide as one burst. The array is written once a burst is full, or when the next write pointer reset pushes out a partial burst. All write-side inputs pass through one register stage before they act, which puts write timing one clock behind read timing. The latency-mode input selects whether a byte presented together with a write reset is already stored, or whether storing starts on the following strobe.

A sequence is the run of cycles between two resets on one side. If a sequence has fewer active cycles than a set minimum, the block raises a one-cycle short-sequence pulse for that side.

Top module: `sfm_field_mem`

## Requirements
- R1: On a write strobe cycle, a byte is taken in and the write pointer advances only when both `wr_en` and `wr_ie` are 1. A 0 on either input, or a 0 on `wr_stb`, leaves the pointer unchanged and drops the byte.
- R2: Every write-side input is registered once before it acts. As a result, `wr_err` rises two clocks after the write reset is presented, while `rd_err` rises one clock after the read reset is presented.
- R3: Captured bytes wait in a staging register of BURST bytes. The array is written only when the byte at burst offset BURST-1 is captured. Until then, reads of the staged addresses return the array's earlier contents, because staged bytes are not forwarded to the read side.
- R4: A write reset strobe first commits any staged bytes of a partly filled burst to the array, then sets the write pointer to address 0.
- R5: With `lat_mode`=0, a byte presented in the write reset cycle with both enables high is stored at address 0. With `lat_mode`=1, that byte is dropped, and the first byte stored at address 0 is the one presented on the next active strobe.
- R6: On a read strobe with `rd_en`=1, `rd_data` loads the byte at the read pointer, and the pointer then advances by one. With `rd_en`=0, or with no strobe, `rd_data` holds its value.
- R7: A read strobe with `rd_rst`=1 sets the read pointer to address 0. If `rd_en` is also 1 in that cycle, address 0 is read in that same cycle.
- R8: On every read strobe, `rd_drive` takes the value of `rd_oe`. With 1 the output is driven, and with 0 it stands for high impedance. Between strobes `rd_drive` holds its value.
- R9: When a side's reset strobe ends a sequence that had fewer than MIN_ACT active cycles, that side's error output pulses for one cycle. The first reset after power-up never raises the error. An active write cycle is one that stores a byte. An active read cycle is a read strobe with `rd_en` and `rd_oe` both 1.
- R10: Both pointers wrap from DEPTH-1 to 0. A write sequence longer than DEPTH overwrites the lowest addresses.
- R11: While `rst_n` is low, `rd_data` is 0, and `rd_drive`, `wr_err` and `rd_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lat_mode | input | 1 | Write start latency: 0 stores in the reset cycle, 1 stores from the next cycle |
| wr_stb | input | 1 | Write-side clock-enable strobe |
| wr_rst | input | 1 | Write pointer reset and staging flush |
| wr_en | input | 1 | Write enable |
| wr_ie | input | 1 | Write input enable |
| wr_data | input | DATA_W | Write byte |
| wr_err | output | 1 | Short write sequence pulse |
| rd_stb | input | 1 | Read-side clock-enable strobe |
| rd_rst | input | 1 | Read pointer reset |
| rd_en | input | 1 | Read enable, advances the pointer |
| rd_oe | input | 1 | Output enable |
| rd_data | output | DATA_W | Read byte |
| rd_drive | output | 1 | 1 when `rd_data` is driven, 0 for high impedance |
| rd_err | output | 1 | Short read sequence pulse |

## Verification
The bench builds the block with DEPTH=32, BURST=4 and MIN_ACT=8. With a 32-byte array, a write sequence of 34 bytes crosses the wrap point, and a single read pass of 33 bytes comes back to address 0. A 4-byte burst lets the tests place a partial burst ahead of a flush, and a burst commit in the middle of a sequence, within a few cycles. A minimum of 8 active cycles lets both short and long sequences, and so both the error pulse and its absence, occur within short tests.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic {
    LAT_SAME = 1'b0,
    LAT_NEXT = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/sfm_seq_guard.sv
// Counts the active cycles of one sequence and flags a reset that ends it early.
module sfm_seq_guard #(
  parameter int MIN_ACT = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic seq_rst_i,
  input  logic act_i,
  output logic short_o
);
  localparam int CNT_W = $clog2(MIN_ACT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             err_q, err_d;

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    err_d  = 1'b0;
    if (stb_i) begin
      if (seq_rst_i) begin
        err_d  = seen_q && (cnt_q < CNT_W'(MIN_ACT));
        cnt_d  = act_i ? CNT_W'(1) : '0;
        seen_d = 1'b1;
      end else if (act_i && (cnt_q < CNT_W'(MIN_ACT))) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      err_q  <= err_d;
    end
  end

  assign short_o = err_q;
endmodule

// File: rtl/sfm_row_mem.sv
// Array stored as rows one burst wide: one masked row write port, one byte read port.
module sfm_row_mem #(
  parameter int ROWS   = 64,
  parameter int BURST  = 16,
  parameter int DATA_W = 8,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(BURST)
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [RW-1:0]           wrow_i,
  input  logic [BURST-1:0]        wmask_i,
  input  logic [BURST*DATA_W-1:0] wdata_i,
  input  logic [RW-1:0]           rrow_i,
  input  logic [CW-1:0]           rcol_i,
  output logic [DATA_W-1:0]       rbyte_o
);
  logic [BURST*DATA_W-1:0] mem_q [ROWS];

  // Storage array: left without reset on purpose.
  always_ff @(posedge clk) begin
    for (int j = 0; j < BURST; j++) begin
      if (we_i && wmask_i[j]) begin
        mem_q[wrow_i][j*DATA_W +: DATA_W] <= wdata_i[j*DATA_W +: DATA_W];
      end
    end
  end

  assign rbyte_o = mem_q[rrow_i][rcol_i*DATA_W +: DATA_W];
endmodule

// File: rtl/sfm_wr_ctrl.sv
// Write side: input register stage, pointer, staging register, burst and flush commits.
module sfm_wr_ctrl
  import sfm_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int BURST  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(BURST),
  localparam int RW    = AW - CW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lat_mode_i,
  input  logic                    stb_i,
  input  logic                    rst_i,
  input  logic                    en_i,
  input  logic                    ie_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic                    we_o,
  output logic [RW-1:0]           wrow_o,
  output logic [BURST-1:0]        wmask_o,
  output logic [BURST*DATA_W-1:0] wdata_o,
  output logic                    seq_stb_o,
  output logic                    seq_rst_o,
  output logic                    seq_act_o
);
  // One register stage puts write timing a clock behind read timing.
  logic              p_stb_q, p_rst_q, p_en_q, p_ie_q;
  lat_mode_e         p_mode_q;
  logic [DATA_W-1:0] p_data_q;

  logic [AW-1:0]                  ptr_q, ptr_d, base;
  logic [BURST-1:0][DATA_W-1:0]   stage_q, stage_d;
  logic [BURST-1:0][DATA_W-1:0]   wrow_data;
  logic [BURST-1:0]               part_mask;
  logic                           cap, flush, full;
  logic [CW-1:0]                  col_q, base_col;

  assign col_q    = ptr_q[CW-1:0];
  assign base     = p_rst_q ? '0 : ptr_q;
  assign base_col = base[CW-1:0];
  assign cap      = p_stb_q && p_en_q && p_ie_q && (!p_rst_q || (p_mode_q == LAT_SAME));
  assign flush    = p_stb_q && p_rst_q && (col_q != '0);
  assign full     = cap && (base_col == CW'(BURST - 1));

  for (genvar j = 0; j < BURST; j++) begin : g_mask
    assign part_mask[j] = CW'(j) < col_q;
  end

  always_comb begin
    ptr_d   = ptr_q;
    stage_d = stage_q;
    if (p_stb_q) begin
      if (cap) begin
        stage_d[base_col] = p_data_q;
        ptr_d             = base + 1'b1;
      end else if (p_rst_q) begin
        ptr_d = '0;
      end
    end
  end

  always_comb begin
    wrow_data = stage_q;
    if (full) wrow_data[BURST-1] = p_data_q;
  end

  assign we_o    = flush || full;
  assign wrow_o  = flush ? ptr_q[AW-1:CW] : base[AW-1:CW];
  assign wmask_o = flush ? part_mask : '1;
  assign wdata_o = wrow_data;

  assign seq_stb_o = p_stb_q;
  assign seq_rst_o = p_rst_q;
  assign seq_act_o = cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_stb_q  <= 1'b0;
      p_rst_q  <= 1'b0;
      p_en_q   <= 1'b0;
      p_ie_q   <= 1'b0;
      p_mode_q <= LAT_SAME;
      p_data_q <= '0;
      ptr_q    <= '0;
      stage_q  <= '0;
    end else begin
      p_stb_q  <= stb_i;
      p_rst_q  <= rst_i;
      p_en_q   <= en_i;
      p_ie_q   <= ie_i;
      p_mode_q <= lat_mode_e'(lat_mode_i);
      p_data_q <= data_i;
      ptr_q    <= ptr_d;
      stage_q  <= stage_d;
    end
  end
endmodule

// File: rtl/sfm_rd_ctrl.sv
// Read side: pointer, output byte register and drive flag.
module sfm_rd_ctrl #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] mem_byte_i,
  output logic [AW-1:0]     raddr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic [AW-1:0]     ptr_q, ptr_d, base;
  logic [DATA_W-1:0] data_q, data_d;
  logic              drive_q, drive_d;

  assign base    = rst_i ? '0 : ptr_q;
  assign raddr_o = base;

  always_comb begin
    ptr_d   = ptr_q;
    data_d  = data_q;
    drive_d = drive_q;
    if (stb_i) begin
      drive_d = oe_i;
      if (en_i) begin
        data_d = mem_byte_i;
        ptr_d  = base + 1'b1;
      end else if (rst_i) begin
        ptr_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      data_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      data_q  <= data_d;
      drive_q <= drive_d;
    end
  end

  assign data_o  = data_q;
  assign drive_o = drive_q;
endmodule

// File: rtl/sfm_field_mem.sv
// Sequential field memory top: write side, row array, read side, two sequence guards.
module sfm_field_mem #(
  parameter int DEPTH   = 1024,
  parameter int BURST   = 16,
  parameter int DATA_W  = 8,
  parameter int MIN_ACT = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_mode,
  input  logic              wr_stb,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic              wr_ie,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  input  logic              rd_stb,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic              rd_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              rd_err
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(BURST);
  localparam int RW   = AW - CW;
  localparam int ROWS = DEPTH / BURST;

  logic                    mem_we;
  logic [RW-1:0]           mem_wrow;
  logic [BURST-1:0]        mem_wmask;
  logic [BURST*DATA_W-1:0] mem_wdata;
  logic [AW-1:0]           rd_addr;
  logic [DATA_W-1:0]       mem_rbyte;
  logic                    w_seq_stb, w_seq_rst, w_seq_act;
  logic                    r_seq_act;

  sfm_wr_ctrl #(.DEPTH(DEPTH), .BURST(BURST), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .lat_mode_i(lat_mode),
    .stb_i(wr_stb), .rst_i(wr_rst), .en_i(wr_en), .ie_i(wr_ie), .data_i(wr_data),
    .we_o(mem_we), .wrow_o(mem_wrow), .wmask_o(mem_wmask), .wdata_o(mem_wdata),
    .seq_stb_o(w_seq_stb), .seq_rst_o(w_seq_rst), .seq_act_o(w_seq_act)
  );

  sfm_row_mem #(.ROWS(ROWS), .BURST(BURST), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we_i(mem_we), .wrow_i(mem_wrow), .wmask_i(mem_wmask),
    .wdata_i(mem_wdata), .rrow_i(rd_addr[AW-1:CW]), .rcol_i(rd_addr[CW-1:0]),
    .rbyte_o(mem_rbyte)
  );

  sfm_rd_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .stb_i(rd_stb), .rst_i(rd_rst), .en_i(rd_en),
    .oe_i(rd_oe), .mem_byte_i(mem_rbyte), .raddr_o(rd_addr),
    .data_o(rd_data), .drive_o(rd_drive)
  );

  assign r_seq_act = rd_en && rd_oe;

  sfm_seq_guard #(.MIN_ACT(MIN_ACT)) u_wguard (
    .clk(clk), .rst_n(rst_n), .stb_i(w_seq_stb), .seq_rst_i(w_seq_rst),
    .act_i(w_seq_act), .short_o(wr_err)
  );

  sfm_seq_guard #(.MIN_ACT(MIN_ACT)) u_rguard (
    .clk(clk), .rst_n(rst_n), .stb_i(rd_stb), .seq_rst_i(rd_rst),
    .act_i(r_seq_act), .short_o(rd_err)
  );
endmodule

// File: rtl/sfm_field_mem_chk.sv
module sfm_field_mem_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              wr_rst,
  input logic              wr_err,
  input logic              rd_stb,
  input logic              rd_rst,
  input logic              rd_en,
  input logic              rd_oe,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive,
  input logic              rd_err
);
  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(rd_data) && $stable(rd_drive)));                 // R6
  AST_RD_NOEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_en) |=> $stable(rd_data));                             // R6
  AST_DRIVE_FOLLOWS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (rd_drive == $past(rd_oe)));                               // R8
  AST_RD_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(rd_stb && rd_rst));                                  // R9
  AST_WR_ERR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_stb && wr_rst, 2));                               // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!rd_drive && !wr_err && !rd_err && (rd_data == '0)));      // R11
endmodule

bind sfm_field_mem sfm_field_mem_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_rst(wr_rst), .wr_err(wr_err),
  .rd_stb(rd_stb), .rd_rst(rd_rst), .rd_en(rd_en), .rd_oe(rd_oe),
  .rd_data(rd_data), .rd_drive(rd_drive), .rd_err(rd_err)
);

// File: tb/test_sfm_field_mem.sv
module test_sfm_field_mem;
  localparam int DEPTH = 32;
  localparam int BURST = 4;
  localparam int DW    = 8;
  localparam int MINA  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lat_mode = 1'b0;
  logic          wr_stb = 1'b0, wr_rst = 1'b0, wr_en = 1'b0, wr_ie = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_err;
  logic          rd_stb = 1'b0, rd_rst = 1'b0, rd_en = 1'b0, rd_oe = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_drive, rd_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sfm_field_mem #(.DEPTH(DEPTH), .BURST(BURST), .DATA_W(DW), .MIN_ACT(MINA)) i_sfm_field_mem (
    .clk(clk), .rst_n(rst_n), .lat_mode(lat_mode),
    .wr_stb(wr_stb), .wr_rst(wr_rst), .wr_en(wr_en), .wr_ie(wr_ie), .wr_data(wr_data),
    .wr_err(wr_err), .rd_stb(rd_stb), .rd_rst(rd_rst), .rd_en(rd_en), .rd_oe(rd_oe),
    .rd_data(rd_data), .rd_drive(rd_drive), .rd_err(rd_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_cyc(input logic s, input logic r, input logic e, input logic i, input logic [DW-1:0] d);
    wr_stb = s; wr_rst = r; wr_en = e; wr_ie = i; wr_data = d;
    tick();
    wr_stb = 1'b0; wr_rst = 1'b0; wr_en = 1'b0; wr_ie = 1'b0;
  endtask

  task automatic rd_cyc(input logic s, input logic r, input logic e, input logic o);
    rd_stb = s; rd_rst = r; rd_en = e; rd_oe = o;
    tick();
    rd_stb = 1'b0; rd_rst = 1'b0; rd_en = 1'b0;
  endtask

  // Read addresses 0..n-1 from a fresh read reset and compare with exp.
  task automatic read_expect(input string req, input int n, input logic [DW-1:0] exp [8]);
    for (int a = 0; a < n; a++) begin
      rd_cyc(1'b1, a == 0, 1'b1, 1'b1);
      chk(req, rd_data, exp[a]);
    end
  endtask

  task automatic t_reset_state();
    chk("R11 rd_data", rd_data, 0);
    chk("R11 rd_drive", rd_drive, 0);
    chk("R11 errs", {wr_err, rd_err}, 0);
    rst_n = 1'b1;
    idle(1);
    wr_cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    tick();
    chk("R9 first write reset no error", wr_err, 0);
  endtask

  task automatic t_fill_and_wrap_read();
    for (int i = 0; i < DEPTH; i++) wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, DW'(8'h40 + i));
    wr_cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    idle(2);
    rd_cyc(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9 first read reset no error", rd_err, 0);
    chk("R7 read in reset cycle gives addr0", rd_data, 8'h40);
    for (int a = 1; a < DEPTH; a++) begin
      rd_cyc(1'b1, 1'b0, 1'b1, 1'b1);
      chk("R6 sequential read", rd_data, 8'h40 + a);
    end
    rd_cyc(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R10 read pointer wraps", rd_data, 8'h40);
  endtask

  task automatic t_enables();
    logic [DW-1:0] e [8];
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h11);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h22);
    wr_cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h33);
    wr_cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h44);
    wr_cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h55);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h15);
    wr_cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    chk("R2 write error not yet visible", wr_err, 0);
    tick();
    chk("R9 short write sequence flagged", wr_err, 1);
    tick();
    chk("R9 write error is one pulse", wr_err, 0);
    rd_cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 long read sequence no error", rd_err, 0);
    e = '{8'h11, 8'h15, 8'h42, 0, 0, 0, 0, 0};
    read_expect("R1 only fully enabled strobes stored", 3, e);
  endtask

  task automatic t_staging();
    logic [DW-1:0] e [8];
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h90);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h91);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h92);
    idle(2);
    rd_cyc(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9 short read sequence flagged", rd_err, 1);
    chk("R3 staged byte not visible a0", rd_data, 8'h11);
    rd_cyc(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R3 staged byte not visible a1", rd_data, 8'h15);
    rd_cyc(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R3 staged byte not visible a2", rd_data, 8'h42);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h93);
    idle(2);
    e = '{8'h90, 8'h91, 8'h92, 8'h93, 0, 0, 0, 0};
    read_expect("R3 full burst committed", 4, e);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h94);
    wr_cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    idle(2);
    e = '{8'h90, 8'h91, 8'h92, 8'h93, 8'h94, 8'h45, 0, 0};
    read_expect("R4 reset flushes partial burst", 6, e);
  endtask

  task automatic t_latency();
    logic [DW-1:0] e [8];
    lat_mode = 1'b1;
    wr_cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'hA5);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'hB0);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'hB1);
    wr_cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    idle(2);
    e = '{8'hB0, 8'hB1, 8'h92, 0, 0, 0, 0, 0};
    read_expect("R5 mode1 drops reset-cycle byte", 3, e);
    lat_mode = 1'b0;
    wr_cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'hC0);
    wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'hC1);
    wr_cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    idle(2);
    e = '{8'hC0, 8'hC1, 8'h92, 0, 0, 0, 0, 0};
    read_expect("R5 mode0 stores reset-cycle byte", 3, e);
  endtask

  task automatic t_read_controls();
    rd_cyc(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R7 reset read addr0", rd_data, 8'hC0);
    chk("R8 drive off with oe low", rd_drive, 0);
    rd_cyc(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R6 hold with rd_en low", rd_data, 8'hC0);
    chk("R8 drive on with oe high", rd_drive, 1);
    rd_cyc(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6 pointer held by rd_en low", rd_data, 8'hC1);
    rd_oe = 1'b0;
    rd_cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 hold without strobe", rd_data, 8'hC1);
    chk("R8 drive holds without strobe", rd_drive, 1);
    rd_cyc(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6 pointer held without strobe", rd_data, 8'h92);
  endtask

  task automatic t_write_wrap();
    logic [DW-1:0] e [8];
    for (int i = 0; i < DEPTH + 2; i++) wr_cyc(1'b1, 1'b0, 1'b1, 1'b1, DW'(8'h60 + i));
    wr_cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    idle(2);
    e = '{8'h80, 8'h81, 8'h62, 0, 0, 0, 0, 0};
    read_expect("R10 write pointer wraps", 3, e);
  endtask

  initial begin
    idle(2);
    t_reset_state();
    t_fill_and_wrap_read();
    t_enables();
    t_staging();
    t_latency();
    t_read_controls();
    t_write_wrap();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule